// File: doc/BRIEF.md
# Region-Selected Bus RAM with Gated Access Strobe

This block is a small read/write memory that hangs off a shared data bus. The low-order address bits pick a word inside the block. The upper address bits are compared against one configured region value. An access is started by a local strobe, and there is no free-running clock inside the block. That strobe is the AND of three terms: the system clock, a system-wide memory-select line, and the region match. Storage reacts only to the rising edge of this strobe. A level on the read/not-write line chooses whether that edge stores the bus data or presents the word on the bus.

The data path is made of identical 4-bit lanes. All lanes share address and control, and each lane owns only its own data bits. The block does not drive the bus as a real tri-state. Instead it provides an output-enable and a data-out vector, and the enclosing bus fabric merges them. The enable is raised only for a read that the strobe has selected.

Top module: `gsram_bus_ram`

## Requirements
- R1: After reset (rst_n low), every word reads back as zero.
- R2: On a rising edge of the access strobe with rd_nwr low (0 = write), bus_din is stored at the word given by the low ADDR_LO_W bits of addr.
- R3: While sys_clk, mem_sel and the region match are all high and rd_nwr is high (1 = read), bus_oe is high and bus_dout shows the stored word at the addressed location.
- R4: With mem_sel low, no word changes and bus_oe stays low.
- R5: When the upper ADDR_HI_W bits of addr differ from REGION, no word changes and bus_oe stays low.
- R6: bus_oe is low during the low phase of sys_clk, and bus_dout is all zeros whenever bus_oe is low.
- R7: Each 4-bit lane stores its own bits (bits 3:0 in lane 0, bits 7:4 in lane 1 at the default width), and words at different addresses do not affect one another.
- R8: A selected write never raises bus_oe.
- R9: A read leaves the stored contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock, gated locally to form the access strobe |
| rst_n | input | 1 | Asynchronous active-low reset, clears all words |
| mem_sel | input | 1 | System-wide memory-select qualifier |
| addr | input | ADDR_HI_W+ADDR_LO_W | Upper bits: region; lower bits: word index |
| rd_nwr | input | 1 | 1 = read, 0 = write |
| bus_din | input | DATA_W | Data taken from the shared bus on writes |
| bus_dout | output | DATA_W | Word presented to the bus, zero when not enabled |
| bus_oe | output | 1 | Bus drive enable for a selected read |

## Verification
The hardest case to reach is one where the strobe must stay quiet while nearly all of its terms are true. Examples are a write aimed at the right word with mem_sel low, or a write with mem_sel high but the upper address one step away from the region. Either case would corrupt a word if a gating term leaked. The stimulus first loads known, distinct patterns into those words. It then issues the near-miss writes with different data, and finally reads the same words back under a full selection. Any leak therefore shows up as a changed word on bus_dout.

// File: rtl/gsram_pkg.sv
`timescale 1ns/1ps
package gsram_pkg;
  localparam int unsigned LANE_W = 4;

  function automatic int unsigned lane_count(input int unsigned data_w);
    return data_w / LANE_W;
  endfunction

  function automatic logic region_match(input logic [31:0] hi, input logic [31:0] region,
                                        input int unsigned hi_w);
    logic [31:0] mask;
    mask = (hi_w >= 32) ? 32'hFFFF_FFFF : ((32'd1 << hi_w) - 32'd1);
    return ((hi & mask) == (region & mask));
  endfunction
endpackage

// File: rtl/gsram_region_dec.sv
`timescale 1ns/1ps
module gsram_region_dec #(
  parameter int unsigned HI_W   = 4,
  parameter logic [HI_W-1:0] REGION = '0
) (
  input  logic [HI_W-1:0] addr_hi,
  output logic            hit
);
  import gsram_pkg::*;
  always_comb begin
    hit = region_match(32'(addr_hi), 32'(REGION), HI_W);
  end
endmodule

// File: rtl/gsram_strobe_gen.sv
`timescale 1ns/1ps
module gsram_strobe_gen (
  input  logic sys_clk,
  input  logic mem_sel,
  input  logic hit,
  output logic mem_clk,
  output logic sel_clk
);
  assign mem_clk = sys_clk & mem_sel;
  assign sel_clk = mem_clk & hit;
endmodule

// File: rtl/gsram_lane.sv
`timescale 1ns/1ps
module gsram_lane #(
  parameter int unsigned ADDR_LO_W = 4,
  parameter int unsigned W         = 4
) (
  input  logic                 sel_clk,
  input  logic                 rst_n,
  input  logic                 rd_nwr,
  input  logic [ADDR_LO_W-1:0] word_idx,
  input  logic [W-1:0]         din,
  input  logic                 oe,
  output logic [W-1:0]         dout
);
  localparam int unsigned DEPTH = 1 << ADDR_LO_W;

  logic [W-1:0] store [DEPTH];

  always_ff @(posedge sel_clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else if (!rd_nwr) begin
      store[word_idx] <= din;
    end
  end

  assign dout = oe ? store[word_idx] : '0;
endmodule

// File: rtl/gsram_bus_ram.sv
`timescale 1ns/1ps
module gsram_bus_ram #(
  parameter int unsigned ADDR_LO_W = 4,
  parameter int unsigned ADDR_HI_W = 4,
  parameter logic [ADDR_HI_W-1:0] REGION = 4'hA,
  parameter int unsigned DATA_W    = 8
) (
  input  logic                           sys_clk,
  input  logic                           rst_n,
  input  logic                           mem_sel,
  input  logic [ADDR_HI_W+ADDR_LO_W-1:0] addr,
  input  logic                           rd_nwr,
  input  logic [DATA_W-1:0]              bus_din,
  output logic [DATA_W-1:0]              bus_dout,
  output logic                           bus_oe
);
  import gsram_pkg::*;
  localparam int unsigned LANES = lane_count(DATA_W);

  logic [ADDR_HI_W-1:0] addr_hi;
  logic [ADDR_LO_W-1:0] addr_lo;
  logic region_hit;
  logic mem_clk;
  logic sel_clk;
  logic wr_strobe_en;

  assign addr_hi = addr[ADDR_HI_W+ADDR_LO_W-1:ADDR_LO_W];
  assign addr_lo = addr[ADDR_LO_W-1:0];

  gsram_region_dec #(.HI_W(ADDR_HI_W), .REGION(REGION)) dec_i (
    .addr_hi(addr_hi), .hit(region_hit));

  gsram_strobe_gen strobe_i (
    .sys_clk(sys_clk), .mem_sel(mem_sel), .hit(region_hit),
    .mem_clk(mem_clk), .sel_clk(sel_clk));

  assign bus_oe       = sel_clk & rd_nwr;
  assign wr_strobe_en = mem_sel & region_hit & ~rd_nwr;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    gsram_lane #(.ADDR_LO_W(ADDR_LO_W), .W(LANE_W)) lane_i (
      .sel_clk (sel_clk),
      .rst_n   (rst_n),
      .rd_nwr  (rd_nwr),
      .word_idx(addr_lo),
      .din     (bus_din[g*LANE_W +: LANE_W]),
      .oe      (bus_oe),
      .dout    (bus_dout[g*LANE_W +: LANE_W]));
  end
endmodule

// File: rtl/gsram_bus_ram_chk.sv
`timescale 1ns/1ps
module gsram_bus_ram_chk #(
  parameter int unsigned ADDR_HI_W = 4,
  parameter logic [ADDR_HI_W-1:0] REGION = 4'hA,
  parameter int unsigned DATA_W = 8
) (
  input logic                 sys_clk,
  input logic                 rst_n,
  input logic                 mem_sel,
  input logic                 rd_nwr,
  input logic [ADDR_HI_W-1:0] addr_hi,
  input logic                 region_hit,
  input logic                 sel_clk,
  input logic                 wr_strobe_en,
  input logic                 bus_oe,
  input logic [DATA_W-1:0]    bus_dout
);
  // High phase sampled at the falling edge.
  p_oe_needs_msel_r4: assert property (@(negedge sys_clk) disable iff (!rst_n)
    bus_oe |-> mem_sel);
  p_oe_needs_region_r5: assert property (@(negedge sys_clk) disable iff (!rst_n)
    bus_oe |-> (region_hit && addr_hi == REGION));
  p_no_oe_on_write_r8: assert property (@(negedge sys_clk) disable iff (!rst_n)
    wr_strobe_en |-> !bus_oe);
  p_strobe_follows_r3: assert property (@(negedge sys_clk) disable iff (!rst_n)
    (mem_sel && region_hit) |-> sel_clk);
  p_quiet_bus_r6: assert property (@(negedge sys_clk) disable iff (!rst_n)
    !bus_oe |-> (bus_dout == '0));
  // Low phase sampled at the rising edge.
  p_low_phase_idle_r6: assert property (@(posedge sys_clk) disable iff (!rst_n)
    !sel_clk && !bus_oe);
endmodule

bind gsram_bus_ram gsram_bus_ram_chk #(
  .ADDR_HI_W(ADDR_HI_W), .REGION(REGION), .DATA_W(DATA_W)
) chk_i (
  .sys_clk(sys_clk), .rst_n(rst_n), .mem_sel(mem_sel), .rd_nwr(rd_nwr),
  .addr_hi(addr_hi), .region_hit(region_hit), .sel_clk(sel_clk),
  .wr_strobe_en(wr_strobe_en), .bus_oe(bus_oe), .bus_dout(bus_dout));

// File: tb/gsram_bus_ram_tb_top.sv
`timescale 1ns/1ps
module gsram_bus_ram_tb_top;
  localparam int unsigned LO_W = 4;
  localparam int unsigned HI_W = 4;
  localparam logic [HI_W-1:0] REG = 4'hA;
  localparam int unsigned DW = 8;

  typedef struct {
    logic          oe;
    logic [DW-1:0] dout;
    string         tag;
  } exp_t;

  logic sys_clk = 1'b0;
  logic rst_n = 1'b0;
  logic mem_sel = 1'b0;
  logic [HI_W+LO_W-1:0] addr = '0;
  logic rd_nwr = 1'b1;
  logic [DW-1:0] bus_din = '0;
  logic [DW-1:0] bus_dout;
  logic bus_oe;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;
  exp_t sb_q[$];
  logic [DW-1:0] model [1 << LO_W];

  gsram_bus_ram #(.ADDR_LO_W(LO_W), .ADDR_HI_W(HI_W), .REGION(REG), .DATA_W(DW)) dut_i (
    .sys_clk(sys_clk), .rst_n(rst_n), .mem_sel(mem_sel), .addr(addr),
    .rd_nwr(rd_nwr), .bus_din(bus_din), .bus_dout(bus_dout), .bus_oe(bus_oe));

  always #10 sys_clk = ~sys_clk;

  task automatic check(input string tag, input logic [DW:0] act, input logic [DW:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual oe/data=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: inputs change in the low phase; expected high-phase result queued.
  task automatic cyc(input logic ms, input logic [HI_W+LO_W-1:0] a, input logic rnw,
                     input logic [DW-1:0] d, input string tag);
    exp_t e;
    logic hit;
    @(negedge sys_clk);
    mem_sel = ms; addr = a; rd_nwr = rnw; bus_din = d;
    hit = ms && (a[HI_W+LO_W-1:LO_W] == REG);
    e.oe = hit && rnw;
    e.dout = e.oe ? model[a[LO_W-1:0]] : '0;
    e.tag = tag;
    sb_q.push_back(e);
    if (hit && !rnw) model[a[LO_W-1:0]] = d;
    #2 check({tag, " R6 low phase"}, {bus_oe, bus_dout}, '0);
  endtask

  // Monitor: compare in the high phase.
  initial begin
    forever begin
      @(posedge sys_clk);
      #5;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.tag, {bus_oe, bus_dout}, {e.oe, e.dout});
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << LO_W); i++) model[i] = '0;
    repeat (3) @(negedge sys_clk);
    check("R1 outputs in reset", {bus_oe, bus_dout}, '0);
    rst_n = 1'b1;
    for (int i = 0; i < (1 << LO_W); i++) cyc(1, {REG, 4'(i)}, 1, 8'h00, "R1 reset content");
    // R2/R7: distinct lanes and addresses
    for (int i = 0; i < (1 << LO_W); i++) cyc(1, {REG, 4'(i)}, 0, {4'(~i), 4'(i + 3)}, "R8 write cycle");
    for (int i = 0; i < (1 << LO_W); i++) cyc(1, {REG, 4'(i)}, 1, 8'h00, "R2 R7 readback");
    cyc(1, {REG, 4'h0}, 0, 8'hFF, "R8 write max");
    cyc(1, {REG, 4'hF}, 0, 8'h00, "R8 write zero");
    cyc(1, {REG, 4'h0}, 1, 8'h00, "R2 addr0 max");
    cyc(1, {REG, 4'hF}, 1, 8'h00, "R2 addr15 zero");
    cyc(1, {REG, 4'h1}, 1, 8'h00, "R7 neighbour kept");
    // R4: memory select low
    cyc(0, {REG, 4'h5}, 0, 8'h3C, "R4 write ignored");
    cyc(0, {REG, 4'h5}, 1, 8'h00, "R4 no drive");
    cyc(1, {REG, 4'h5}, 1, 8'h00, "R4 word unchanged");
    // R5: adjacent regions
    cyc(1, {4'(REG + 1), 4'h6}, 0, 8'hC3, "R5 write ignored hi+1");
    cyc(1, {4'(REG - 1), 4'h6}, 0, 8'h5A, "R5 write ignored hi-1");
    cyc(1, {4'(REG + 1), 4'h6}, 1, 8'h00, "R5 no drive");
    cyc(1, {REG, 4'h6}, 1, 8'h00, "R5 word unchanged");
    // R9: repeated reads
    cyc(1, {REG, 4'h9}, 1, 8'hEE, "R9 read one");
    cyc(1, {REG, 4'h9}, 1, 8'h11, "R9 read two");
    // R3: lane patterns
    cyc(1, {REG, 4'h7}, 0, 8'hA5, "R8 write pattern");
    cyc(1, {REG, 4'h7}, 1, 8'h00, "R3 R7 lane pattern");
    repeat (3) @(negedge sys_clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule